// File: doc/BRIEF.md
# Long-Mode State and Size Decoder

This block holds the control bits that decide whether a processor core runs in long mode and works out, from those bits and the bits of the current code segment, which execution mode is in force and what operand and address sizes an instruction gets by default. Software-visible writes arrive as one-cycle strobes with a data bit: one for the paging switch, one for the long-mode enable, one carrying the code segment's long and default bits, and one marking a load of the page-base register. Two or three prefix flags from the instruction being decoded then adjust the default sizes within the same cycle.

A sequence watcher follows the way software leaves long mode. It reports any step taken out of order, and any attempt to change the long-mode enable while paging is on, as a one-cycle error pulse. The block also keeps a flag that says whether the extra registers that exist only in 64-bit mode still hold meaningful values. The flag survives a trip from 64-bit mode into compatibility mode and back. Other mode changes clear it.

Top module: `xmode_tracker`

## Requirements
- R1: A synchronous reset clears paging, long-mode enable, long-mode active and both segment bits. After reset the mode is legacy (code 0), both sizes are 16 bits (code 0), fault and error are 0 and `xregs_valid` is 1.
- R2: While long mode is inactive, the mode code is 0 and the segment long bit is ignored. The default bit sets both sizes: 1 gives 32 bits (code 1) and 0 gives 16 bits. `osz_pfx` swaps the operand size between 16 and 32 bits, and `asz_pfx` does the same for the address size.
- R3: Writing paging to 1 while the long-mode enable is already 1 sets `lma` in the next cycle. Writing paging to 1 while the enable is 0 leaves `lma` at 0.
- R4: In long mode with long=1 and default=0, the mode code is 2 and the sizes are 32-bit operand and 64-bit address (code 2). `wide_pfx` gives a 64-bit operand and wins over `osz_pfx`. `osz_pfx` alone gives 16 bits. `asz_pfx` gives a 32-bit address.
- R5: In long mode with long=0, the mode code is 1 and the sizes follow the default bit as in R2. `wide_pfx` has no effect.
- R6: In long mode with long=1 and default=1, the mode code is 3, `rsv_fault` is 1 and both sizes are 32 bits.
- R7: A paging write of 0 clears `lma` in the next cycle.
- R8: A long-mode-enable write while paging is 1 leaves the enable unchanged and raises `seq_err` for one cycle.
- R9: Leaving long mode must follow this order: compatibility mode, paging cleared, page-base load, enable cleared, paging set. Each of the following raises `seq_err` for one cycle:
  - clearing paging from 64-bit or reserved mode;
  - any paging or enable write that comes before its turn;
  - the wrong data value on a write.

  The segment bits are judged as held before the cycle of the paging write.
- R10: A change from mode 2 to mode 1, followed by a change from mode 1 back to mode 2, leaves `xregs_valid` unchanged.
- R11: Some mode changes leave `xregs_valid` as it is: a change out of legacy mode, and the moves named in R10. Any other change of mode code clears it, and it stays 0 until reset.
- R12: Strobes take effect at the next clock edge. The prefix flags act on the sizes within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pg_wr | input | 1 | Paging switch write strobe |
| pg_val | input | 1 | Paging switch write data |
| lme_wr | input | 1 | Long-mode enable write strobe |
| lme_val | input | 1 | Long-mode enable write data |
| cs_wr | input | 1 | Code segment bits write strobe |
| cs_long | input | 1 | Segment long bit |
| cs_dflt | input | 1 | Segment default-size bit |
| pgbase_wr | input | 1 | Page-base register load strobe |
| osz_pfx | input | 1 | Operand-size override prefix present |
| wide_pfx | input | 1 | 64-bit operand promotion prefix present |
| asz_pfx | input | 1 | Address-size override prefix present |
| lma | output | 1 | Long mode active |
| mode | output | 2 | 0 legacy, 1 compatibility, 2 64-bit, 3 reserved |
| op_size | output | 2 | 0 16-bit, 1 32-bit, 2 64-bit |
| addr_size | output | 2 | 0 16-bit, 1 32-bit, 2 64-bit |
| rsv_fault | output | 1 | Reserved segment encoding in long mode |
| seq_err | output | 1 | One-cycle illegal transition pulse |
| xregs_valid | output | 1 | Extended registers still hold defined values |

## Verification
A single strobe cycle can carry both a segment write and a paging write, so the mode change and the exit-order check land on the same edge. The bench provokes this from the reserved encoding: it writes long=0 in the same cycle that it clears paging. The error pulse must still appear, because the check uses the segment bits held before that edge, and the new default bit must already set the legacy sizes in the next cycle. A long-mode-enable write rejected while paging is on likewise shares its error pulse with unchanged mode outputs. The bench later proves the enable was kept by re-entering long mode with no fresh enable write.

// File: rtl/xmode_pkg.sv
package xmode_pkg;

    typedef enum logic [1:0] {
        MODE_LEGACY = 2'd0,
        MODE_COMPAT = 2'd1,
        MODE_LONG64 = 2'd2,
        MODE_RSVD   = 2'd3
    } xmode_e;

    localparam logic [1:0] SZ_16 = 2'd0;
    localparam logic [1:0] SZ_32 = 2'd1;
    localparam logic [1:0] SZ_64 = 2'd2;

    typedef enum logic [1:0] {
        EXIT_IDLE    = 2'd0,
        EXIT_PG_OFF  = 2'd1,
        EXIT_BASE    = 2'd2,
        EXIT_LME_OFF = 2'd3
    } exit_st_e;

    typedef struct packed {
        logic pg;
        logic lme;
        logic lma;
        logic cs_l;
        logic cs_d;
        logic xvalid;
        logic trip;
    } ctl_t;

    function automatic xmode_e mode_of(input logic act, input logic seg_l, input logic seg_d);
        if (!act)               return MODE_LEGACY;
        else if (!seg_l)        return MODE_COMPAT;
        else if (!seg_d)        return MODE_LONG64;
        else                    return MODE_RSVD;
    endfunction

endpackage

// File: rtl/xmode_size_dec.sv
module xmode_size_dec
    import xmode_pkg::*;
(
    input  xmode_e     mode_i,
    input  logic       seg_d_i,
    input  logic       osz_i,
    input  logic       wide_i,
    input  logic       asz_i,
    output logic [1:0] op_o,
    output logic [1:0] ad_o
);
    logic [1:0] base_sz;
    logic [1:0] alt_sz;

    always_comb begin
        base_sz = seg_d_i ? SZ_32 : SZ_16;
        alt_sz  = seg_d_i ? SZ_16 : SZ_32;
        unique case (mode_i)
            MODE_LONG64: begin
                op_o = wide_i ? SZ_64 : (osz_i ? SZ_16 : SZ_32);
                ad_o = asz_i ? SZ_32 : SZ_64;
            end
            MODE_RSVD: begin
                op_o = SZ_32;
                ad_o = SZ_32;
            end
            default: begin
                op_o = osz_i ? alt_sz : base_sz;
                ad_o = asz_i ? alt_sz : base_sz;
            end
        endcase
    end
endmodule

// File: rtl/xmode_exit_seq.sv
module xmode_exit_seq
    import xmode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pg_wr_i,
    input  logic pg_val_i,
    input  logic lme_wr_i,
    input  logic lme_val_i,
    input  logic base_wr_i,
    input  logic pg_q_i,
    input  logic lma_q_i,
    input  logic seg_l_q_i,
    output logic err_o
);
    typedef struct packed {
        exit_st_e st;
        logic     err;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.err = lme_wr_i && pg_q_i;
        unique case (seq_q.st)
            EXIT_IDLE: begin
                if (pg_wr_i && !pg_val_i && lma_q_i) begin
                    if (seg_l_q_i) seq_d.err = 1'b1;
                    else           seq_d.st  = EXIT_PG_OFF;
                end
            end
            EXIT_PG_OFF: begin
                if (pg_wr_i || lme_wr_i) begin
                    seq_d.err = 1'b1;
                    seq_d.st  = EXIT_IDLE;
                end else if (base_wr_i) begin
                    seq_d.st = EXIT_BASE;
                end
            end
            EXIT_BASE: begin
                if (pg_wr_i || (lme_wr_i && lme_val_i)) begin
                    seq_d.err = 1'b1;
                    seq_d.st  = EXIT_IDLE;
                end else if (lme_wr_i) begin
                    seq_d.st = EXIT_LME_OFF;
                end
            end
            EXIT_LME_OFF: begin
                if (lme_wr_i || (pg_wr_i && !pg_val_i)) begin
                    seq_d.err = 1'b1;
                    seq_d.st  = EXIT_IDLE;
                end else if (pg_wr_i) begin
                    seq_d.st = EXIT_IDLE;
                end
            end
            default: seq_d.st = EXIT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '{st: EXIT_IDLE, err: 1'b0};
        else     seq_q <= seq_d;
    end

    assign err_o = seq_q.err;
endmodule

// File: rtl/xmode_tracker.sv
module xmode_tracker
    import xmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pg_wr,
    input  logic       pg_val,
    input  logic       lme_wr,
    input  logic       lme_val,
    input  logic       cs_wr,
    input  logic       cs_long,
    input  logic       cs_dflt,
    input  logic       pgbase_wr,
    input  logic       osz_pfx,
    input  logic       wide_pfx,
    input  logic       asz_pfx,
    output logic       lma,
    output logic [1:0] mode,
    output logic [1:0] op_size,
    output logic [1:0] addr_size,
    output logic       rsv_fault,
    output logic       seq_err,
    output logic       xregs_valid
);
    localparam ctl_t CTL_RST = '{pg: 1'b0, lme: 1'b0, lma: 1'b0, cs_l: 1'b0,
                                 cs_d: 1'b0, xvalid: 1'b1, trip: 1'b0};

    ctl_t   ctl_d, ctl_q;
    xmode_e mode_cur, mode_nxt;
    logic   pg_en_q, lme_en_q;

    always_comb begin
        ctl_d = ctl_q;
        if (cs_wr) begin
            ctl_d.cs_l = cs_long;
            ctl_d.cs_d = cs_dflt;
        end
        if (lme_wr && !ctl_q.pg) ctl_d.lme = lme_val;
        if (pg_wr) begin
            ctl_d.pg  = pg_val;
            ctl_d.lma = pg_val && ctl_q.lme;
        end
        mode_cur = mode_of(ctl_q.lma, ctl_q.cs_l, ctl_q.cs_d);
        mode_nxt = mode_of(ctl_d.lma, ctl_d.cs_l, ctl_d.cs_d);
        if (mode_nxt != mode_cur) begin
            if (mode_cur == MODE_LONG64 && mode_nxt == MODE_COMPAT) begin
                ctl_d.trip = 1'b1;
            end else if (mode_cur == MODE_COMPAT && mode_nxt == MODE_LONG64 && ctl_q.trip) begin
                ctl_d.trip = 1'b0;
            end else if (mode_cur == MODE_LEGACY) begin
                ctl_d.trip = 1'b0;
            end else begin
                ctl_d.trip   = 1'b0;
                ctl_d.xvalid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RST;
        else     ctl_q <= ctl_d;
    end

    xmode_size_dec u_size (
        .mode_i  (mode_cur),
        .seg_d_i (ctl_q.cs_d),
        .osz_i   (osz_pfx),
        .wide_i  (wide_pfx),
        .asz_i   (asz_pfx),
        .op_o    (op_size),
        .ad_o    (addr_size)
    );

    xmode_exit_seq u_exit (
        .clk       (clk),
        .rst       (rst),
        .pg_wr_i   (pg_wr),
        .pg_val_i  (pg_val),
        .lme_wr_i  (lme_wr),
        .lme_val_i (lme_val),
        .base_wr_i (pgbase_wr),
        .pg_q_i    (ctl_q.pg),
        .lma_q_i   (ctl_q.lma),
        .seg_l_q_i (ctl_q.cs_l),
        .err_o     (seq_err)
    );

    assign pg_en_q     = ctl_q.pg;
    assign lme_en_q    = ctl_q.lme;
    assign lma         = ctl_q.lma;
    assign mode        = mode_cur;
    assign rsv_fault   = (mode_cur == MODE_RSVD);
    assign xregs_valid = ctl_q.xvalid;
endmodule

// File: rtl/xmode_tracker_chk.sv
module xmode_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic       pg_wr,
    input logic       pg_val,
    input logic       lme_wr,
    input logic       lma,
    input logic [1:0] mode,
    input logic [1:0] op_size,
    input logic       rsv_fault,
    input logic       seq_err,
    input logic       xregs_valid,
    input logic       pg_q,
    input logic       lme_q
);
    // R7
    assert_pg_clear_drops_lma_R7: assert property (@(posedge clk) disable iff (rst)
        (pg_wr && !pg_val) |=> !lma);

    // R8
    assert_lme_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (lme_wr && pg_q) |=> ($stable(lme_q) && seq_err));

    // R6
    assert_fault_needs_lma_R6: assert property (@(posedge clk) disable iff (rst)
        rsv_fault |-> (lma && mode == 2'd3));

    // R2
    assert_inactive_is_legacy_R2: assert property (@(posedge clk) disable iff (rst)
        !lma |-> (mode == 2'd0 && !rsv_fault));

    // R4
    assert_wide_only_in_64_R4: assert property (@(posedge clk) disable iff (rst)
        (op_size == 2'd2) |-> (mode == 2'd2));

    // R11
    assert_xvalid_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(xregs_valid)) |-> !xregs_valid);
endmodule

bind xmode_tracker xmode_tracker_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pg_wr       (pg_wr),
    .pg_val      (pg_val),
    .lme_wr      (lme_wr),
    .lma         (lma),
    .mode        (mode),
    .op_size     (op_size),
    .rsv_fault   (rsv_fault),
    .seq_err     (seq_err),
    .xregs_valid (xregs_valid),
    .pg_q        (pg_en_q),
    .lme_q       (lme_en_q)
);

// File: tb/test_xmode_tracker.sv
module test_xmode_tracker;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pg_wr = 0, pg_val = 0, lme_wr = 0, lme_val = 0;
    logic cs_wr = 0, cs_long = 0, cs_dflt = 0, pgbase_wr = 0;
    logic osz_pfx = 0, wide_pfx = 0, asz_pfx = 0;
    logic       lma, rsv_fault, seq_err, xregs_valid;
    logic [1:0] mode, op_size, addr_size;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int         due;
        string      tag;
        logic       lma;
        logic [1:0] mode;
        logic [1:0] op;
        logic [1:0] ad;
        logic       rsv;
        logic       err;
        logic       xv;
    } exp_t;

    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    xmode_tracker i_xmode_tracker (
        .clk(clk), .rst(rst),
        .pg_wr(pg_wr), .pg_val(pg_val), .lme_wr(lme_wr), .lme_val(lme_val),
        .cs_wr(cs_wr), .cs_long(cs_long), .cs_dflt(cs_dflt), .pgbase_wr(pgbase_wr),
        .osz_pfx(osz_pfx), .wide_pfx(wide_pfx), .asz_pfx(asz_pfx),
        .lma(lma), .mode(mode), .op_size(op_size), .addr_size(addr_size),
        .rsv_fault(rsv_fault), .seq_err(seq_err), .xregs_valid(xregs_valid)
    );

    // monitor: compares results due in this cycle, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (e.due != cyc ||
                    {lma, mode, op_size, addr_size, rsv_fault, seq_err, xregs_valid} !==
                    {e.lma, e.mode, e.op, e.ad, e.rsv, e.err, e.xv}) begin
                    errors++;
                    $display("FAIL %s: got lma=%0d mode=%0d op=%0d ad=%0d rsv=%0d err=%0d xv=%0d exp lma=%0d mode=%0d op=%0d ad=%0d rsv=%0d err=%0d xv=%0d",
                             e.tag, lma, mode, op_size, addr_size, rsv_fault, seq_err, xregs_valid,
                             e.lma, e.mode, e.op, e.ad, e.rsv, e.err, e.xv);
                end
            end
        end
    end

    task automatic step(input string tag,
                        input logic pw, input logic pv, input logic lw, input logic lv,
                        input logic cw, input logic cl, input logic cd, input logic bw,
                        input logic [2:0] pfx,
                        input logic e_lma, input logic [1:0] e_mode,
                        input logic [1:0] e_op, input logic [1:0] e_ad,
                        input logic e_rsv, input logic e_err, input logic e_xv);
        exp_t e;
        @(negedge clk);
        #1;
        pg_wr = pw; pg_val = pv; lme_wr = lw; lme_val = lv;
        cs_wr = cw; cs_long = cl; cs_dflt = cd; pgbase_wr = bw;
        {wide_pfx, osz_pfx, asz_pfx} = pfx;
        e = '{due: cyc + 1, tag: tag, lma: e_lma, mode: e_mode, op: e_op, ad: e_ad,
              rsv: e_rsv, err: e_err, xv: e_xv};
        sb.push_back(e);
        @(posedge clk);
        #1;
        pg_wr = 0; lme_wr = 0; cs_wr = 0; pgbase_wr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1;
        rst = 1'b1;
        pg_wr = 0; lme_wr = 0; cs_wr = 0; pgbase_wr = 0;
        {wide_pfx, osz_pfx, asz_pfx} = 3'b000;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        summary();
    end

    initial begin
        do_reset();
        //    tag                       pw pv lw lv cw cl cd bw pfx     lma mode op ad rsv err xv
        step("R1 reset state",          0, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 1);
        step("R2 legacy default 1",     0, 0, 0, 0, 1, 0, 1, 0, 3'b000, 0, 0, 1, 1, 0, 0, 1);
        step("R2 legacy prefixes",      0, 0, 0, 0, 0, 0, 0, 0, 3'b011, 0, 0, 0, 0, 0, 0, 1);
        step("R2 long bit ignored",     0, 0, 0, 0, 1, 1, 0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 1);
        step("R3 enable set",           0, 0, 1, 1, 0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 1);
        step("R3 enter 64-bit",         1, 1, 0, 0, 0, 0, 0, 0, 3'b000, 1, 2, 1, 2, 0, 0, 1);
        step("R4 wide prefix",          0, 0, 0, 0, 0, 0, 0, 0, 3'b100, 1, 2, 2, 2, 0, 0, 1);
        step("R4 osz asz prefixes",     0, 0, 0, 0, 0, 0, 0, 0, 3'b011, 1, 2, 0, 1, 0, 0, 1);
        step("R12 R4 wide wins",        0, 0, 0, 0, 0, 0, 0, 0, 3'b111, 1, 2, 2, 1, 0, 0, 1);
        step("R8 enable write refused", 0, 0, 1, 0, 0, 0, 0, 0, 3'b000, 1, 2, 1, 2, 0, 1, 1);
        step("R8 error one cycle",      0, 0, 0, 0, 0, 0, 0, 0, 3'b000, 1, 2, 1, 2, 0, 0, 1);
        step("R5 R10 to compat",        0, 0, 0, 0, 1, 0, 1, 0, 3'b000, 1, 1, 1, 1, 0, 0, 1);
        step("R5 wide ignored",         0, 0, 0, 0, 0, 0, 0, 0, 3'b111, 1, 1, 0, 0, 0, 0, 1);
        step("R10 back to 64-bit",      0, 0, 0, 0, 1, 1, 0, 0, 3'b000, 1, 2, 1, 2, 0, 0, 1);
        step("R7 R9 R11 clear from 64", 1, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0, 1, 0);
        step("R8 enable was kept",      1, 1, 0, 0, 0, 0, 0, 0, 3'b000, 1, 2, 1, 2, 0, 0, 0);
        step("R6 reserved encoding",    0, 0, 0, 0, 1, 1, 1, 0, 3'b000, 1, 3, 1, 1, 1, 0, 0);
        step("R9 same-cycle seg+clear", 1, 0, 0, 0, 1, 0, 1, 0, 3'b000, 0, 0, 1, 1, 0, 1, 0);

        do_reset();
        step("R1 reset again",          0, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 1);
        step("R2 setup compat seg",     0, 0, 0, 0, 1, 0, 1, 0, 3'b000, 0, 0, 1, 1, 0, 0, 1);
        step("R3 enable",               0, 0, 1, 1, 0, 0, 0, 0, 3'b000, 0, 0, 1, 1, 0, 0, 1);
        step("R11 legacy to compat",    1, 1, 0, 0, 0, 0, 0, 0, 3'b000, 1, 1, 1, 1, 0, 0, 1);
        step("R9 R11 legal clear",      1, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 1, 1, 0, 0, 0);
        step("R9 base load",            0, 0, 0, 0, 0, 0, 0, 1, 3'b000, 0, 0, 1, 1, 0, 0, 0);
        step("R9 enable clear",         0, 0, 1, 0, 0, 0, 0, 0, 3'b000, 0, 0, 1, 1, 0, 0, 0);
        step("R9 R3 paging on legacy",  1, 1, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 1, 1, 0, 0, 0);
        step("R8 enable while paging",  0, 0, 1, 1, 0, 0, 0, 0, 3'b000, 0, 0, 1, 1, 0, 1, 0);
        step("R9 paging off outside",   1, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 1, 1, 0, 0, 0);
        step("R9 enable set",           0, 0, 1, 1, 0, 0, 0, 0, 3'b000, 0, 0, 1, 1, 0, 0, 0);
        step("R3 re-enter compat",      1, 1, 0, 0, 0, 0, 0, 0, 3'b000, 1, 1, 1, 1, 0, 0, 0);
        step("R9 legal clear 2",        1, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 1, 1, 0, 0, 0);
        step("R9 skipped base load",    1, 1, 0, 0, 0, 0, 0, 0, 3'b000, 1, 1, 1, 1, 0, 1, 0);
        step("R9 legal clear 3",        1, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 1, 1, 0, 0, 0);
        step("R9 base load 2",          0, 0, 0, 0, 0, 0, 0, 1, 3'b000, 0, 0, 1, 1, 0, 0, 0);
        step("R9 skipped enable clear", 1, 1, 0, 0, 0, 0, 0, 0, 3'b000, 1, 1, 1, 1, 0, 1, 0);

        do_reset();
        step("R10 setup 64 seg",        0, 0, 0, 0, 1, 1, 0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 1);
        step("R10 enable",              0, 0, 1, 1, 0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 1);
        step("R10 enter 64",            1, 1, 0, 0, 0, 0, 0, 0, 3'b000, 1, 2, 1, 2, 0, 0, 1);
        step("R10 R5 compat 16",        0, 0, 0, 0, 1, 0, 0, 0, 3'b000, 1, 1, 0, 0, 0, 0, 1);
        step("R10 round trip done",     0, 0, 0, 0, 1, 1, 0, 0, 3'b000, 1, 2, 1, 2, 0, 0, 1);

        do_reset();
        step("R11 setup compat seg",    0, 0, 0, 0, 1, 0, 1, 0, 3'b000, 0, 0, 1, 1, 0, 0, 1);
        step("R11 enable",              0, 0, 1, 1, 0, 0, 0, 0, 3'b000, 0, 0, 1, 1, 0, 0, 1);
        step("R11 enter compat",        1, 1, 0, 0, 0, 0, 0, 0, 3'b000, 1, 1, 1, 1, 0, 0, 1);
        step("R11 compat to 64 no trip",0, 0, 0, 0, 1, 1, 0, 0, 3'b000, 1, 2, 1, 2, 0, 0, 0);
        step("R11 stays cleared",       0, 0, 0, 0, 1, 0, 0, 0, 3'b000, 1, 1, 0, 0, 0, 0, 0);

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R12: got %0d pending results exp 0", sb.size());
        end
        summary();
    end
endmodule